// File: doc/BRIEF.md
# Dual-Buffer Frame Transmit Controller

This block is the transmit half of a small memory-mapped Ethernet MAC. It holds two transmit buffers in a shared RAM. Each buffer has a length register and a control register, and buffer 0 also carries a global interrupt enable. The host fills a buffer with frame bytes through a 32-bit word interface and sets the frame length. It then writes the buffer's control register with the start bit set.

If the program bit is clear, a start write sends the frame. The frame goes out byte by byte on a valid/ready/last stream. If the program bit is set, the start write loads a new 48-bit station address from the first six bytes of the buffer, and the address is handed to the receive side. When either operation finishes, a one-cycle interrupt pulse can be raised. The pulse needs both the buffer's own enable bit and the global enable.

Each buffer reports busy through its start bit until its operation completes. A single engine serves the buffers, so a request for one buffer is held until the other buffer's operation is done. CRC, preamble, PHY signalling and collisions belong to other blocks.

Top module: `lite_tx_ctrl`

## Requirements
- R1: Each buffer occupies `BUF_BYTES` bytes of host address space, with buffer 1 starting at byte offset `BUF_BYTES`. Words below offset `BUF_BYTES-12` inside a buffer are frame RAM and read back as written. The byte at address 4k+j is carried in bits [8j+7:8j] of word k.
- R2: Within each buffer, the length register sits at offset `BUF_BYTES-12` and the control register at `BUF_BYTES-4`. The global enable sits at offset `BUF_BYTES-8` of buffer 0 only. Length and global enable read back exactly as written. Control reads back as written except that bit 1 reads 0 and bit 0 reads the busy state. Reads return data one cycle after the request.
- R3: A control write with bit 0 = 1 and bit 1 = 0 sends the number of bytes in that buffer's length register. Bytes go out in ascending address order, and last is high only on the final byte.
- R4: While valid is high and ready is low, the output byte and last stay unchanged, and valid stays high.
- R5: A control write with bit 0 = 1 and bit 1 = 1 loads the station address from buffer bytes 0..5, with byte 0 in bits [47:40] and byte 5 in bits [7:0]. No byte is streamed.
- R6: Control bit 0 reads 1 from the cycle after an accepted start until the operation finishes, then reads 0. Any control write to a busy buffer is ignored: the stored value is unchanged and no second operation starts.
- R7: On completion, `irq` pulses high for one cycle only if the finishing buffer's control bit 3 and global enable bit 31 are both 1.
- R8: After reset, the station address equals `STA_DEFAULT`, all registers read 0, and `tx_valid` and `irq` are low.
- R9: A start on the idle buffer while the other buffer is busy is held pending (reads busy) and runs after the other buffer finishes.
- R10: A length of 0 completes a transmit request without streaming any byte, and the interrupt rules still apply. A control write with bit 0 = 0 stores its bits and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_en | input | 1 | Host access request this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | HAW | Byte address, word aligned |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid the cycle after a read |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | Byte available |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_last | output | 1 | Final byte of the frame |
| station_addr | output | 48 | Current station address for the receive side |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The bench builds the block with its default parameters: 2048-byte buffers and the default station address. With these values the real register offsets 0x7F4, 0x7F8 and 0x7FC, and the 0x800 step to buffer 1, are exercised directly. The 11-bit length field lets frames of odd lengths end in every byte lane, and lets a zero-length request and multi-word frames run under three ready patterns: always ready, never ready and periodically stalled. Holding ready low keeps a buffer busy for as long as needed, which makes the busy-write and queued-buffer cases reachable.

// File: rtl/lite_tx_pkg.sv
package lite_tx_pkg;

    localparam int CTRL_START = 0;
    localparam int CTRL_PROG  = 1;
    localparam int CTRL_IRQ   = 3;
    localparam int GIE_BIT    = 31;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_SEND  = 2'd1,
        ENG_PROG0 = 2'd2,
        ENG_PROG1 = 2'd3
    } eng_state_e;

    typedef struct packed {
        logic [1:0][31:0] len;
        logic [31:0]      gie;
        logic [1:0][31:0] ctrl;
        logic [1:0]       pend;
        logic [1:0]       prog;
        logic             irq;
        logic [31:0]      rdata;
    } regs_t;

endpackage

// File: rtl/lite_tx_bufmem.sv
module lite_tx_bufmem #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [31:0]   wr_data,
    input  logic [AW-1:0] hrd_addr,
    output logic [31:0]   hrd_data,
    input  logic [AW-1:0] erd_addr,
    output logic [31:0]   erd_data
);
    localparam int DEPTH = 1 << AW;

    logic [31:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign hrd_data = mem_q[hrd_addr];
    assign erd_data = mem_q[erd_addr];

endmodule

// File: rtl/lite_tx_regs.sv
module lite_tx_regs
    import lite_tx_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    localparam int OFF_W    = $clog2(BUF_BYTES),
    localparam int HAW      = OFF_W + 1,
    localparam int WIDX_W   = OFF_W - 2,
    localparam int MEM_AW   = WIDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [HAW-1:0]    host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              mem_wr_en,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [31:0]       mem_wr_data,
    input  logic [31:0]       mem_rd_data,
    output logic [1:0]        pend_o,
    output logic [1:0]        prog_o,
    output logic [1:0][31:0]  len_o,
    input  logic              done_i,
    input  logic              done_buf_i,
    output logic              irq_o
);
    localparam int BUF_WORDS = BUF_BYTES / 4;
    localparam logic [WIDX_W-1:0] LEN_WORD  = WIDX_W'(BUF_WORDS - 3);
    localparam logic [WIDX_W-1:0] GIE_WORD  = WIDX_W'(BUF_WORDS - 2);
    localparam logic [WIDX_W-1:0] CTRL_WORD = WIDX_W'(BUF_WORDS - 1);

    regs_t q, d;

    logic              bsel;
    logic [WIDX_W-1:0] widx;
    logic              is_data;
    logic              wr_acc;
    logic              rd_acc;

    assign bsel    = host_addr[HAW-1];
    assign widx    = host_addr[OFF_W-1:2];
    assign is_data = (widx < LEN_WORD);
    assign wr_acc  = host_en && host_we;
    assign rd_acc  = host_en && !host_we;

    assign mem_addr    = {bsel, widx};
    assign mem_wr_en   = wr_acc && is_data;
    assign mem_wr_data = host_wdata;

    always_comb begin
        d     = q;
        d.irq = 1'b0;

        if (done_i) begin
            d.pend[done_buf_i] = 1'b0;
            d.irq = q.ctrl[done_buf_i][CTRL_IRQ] && q.gie[GIE_BIT];
        end

        if (wr_acc) begin
            if (widx == LEN_WORD) begin
                d.len[bsel] = host_wdata;
            end else if (widx == GIE_WORD && !bsel) begin
                d.gie = host_wdata;
            end else if (widx == CTRL_WORD && !q.pend[bsel]) begin
                d.ctrl[bsel] = host_wdata & ~32'h3;
                if (host_wdata[CTRL_START]) begin
                    d.pend[bsel] = 1'b1;
                    d.prog[bsel] = host_wdata[CTRL_PROG];
                end
            end
        end

        if (rd_acc) begin
            if (is_data) begin
                d.rdata = mem_rd_data;
            end else if (widx == LEN_WORD) begin
                d.rdata = q.len[bsel];
            end else if (widx == GIE_WORD) begin
                d.rdata = bsel ? 32'h0 : q.gie;
            end else begin
                d.rdata = q.ctrl[bsel] | {31'h0, q.pend[bsel]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign host_rdata = q.rdata;
    assign pend_o     = q.pend;
    assign prog_o     = q.prog;
    assign len_o      = q.len;
    assign irq_o      = q.irq;

    p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq |=> !q.irq);

    p_busy_ctrl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && widx == CTRL_WORD && q.pend[bsel]) |=> (q.ctrl == $past(q.ctrl)));

    p_done_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !q.pend[$past(done_buf_i)]);

endmodule

// File: rtl/lite_tx_engine.sv
module lite_tx_engine
    import lite_tx_pkg::*;
#(
    parameter int          BUF_BYTES   = 2048,
    parameter logic [47:0] STA_DEFAULT = 48'h0200_0000_0001,
    localparam int LEN_W  = $clog2(BUF_BYTES),
    localparam int WIDX_W = LEN_W - 2,
    localparam int MEM_AW = WIDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        pend_i,
    input  logic [1:0]        prog_i,
    input  logic [1:0][31:0]  len_i,
    output logic [MEM_AW-1:0] mem_addr_o,
    input  logic [31:0]       mem_data_i,
    output logic [7:0]        tx_data_o,
    output logic              tx_valid_o,
    input  logic              tx_ready_i,
    output logic              tx_last_o,
    output logic [47:0]       sta_o,
    output logic              done_o,
    output logic              done_buf_o
);
    typedef struct packed {
        eng_state_e       state;
        logic             cur;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] len;
        logic [47:0]      sta;
        logic             done;
        logic             done_buf;
    } eng_t;

    eng_t q, d;

    logic              final_byte;
    logic [WIDX_W-1:0] word_sel;
    logic              pick;

    assign final_byte = (q.cnt == q.len - LEN_W'(1));
    assign pick       = !pend_i[0];

    always_comb begin
        case (q.state)
            ENG_PROG0: word_sel = '0;
            ENG_PROG1: word_sel = WIDX_W'(1);
            default:   word_sel = q.cnt[LEN_W-1:2];
        endcase
    end

    assign mem_addr_o = {q.cur, word_sel};

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.state)
            ENG_IDLE: begin
                if (!q.done && (|pend_i)) begin
                    d.cur = pick;
                    d.cnt = '0;
                    d.len = len_i[pick][LEN_W-1:0];
                    if (prog_i[pick]) begin
                        d.state = ENG_PROG0;
                    end else if (len_i[pick][LEN_W-1:0] == '0) begin
                        d.done     = 1'b1;
                        d.done_buf = pick;
                    end else begin
                        d.state = ENG_SEND;
                    end
                end
            end
            ENG_SEND: begin
                if (tx_ready_i) begin
                    if (final_byte) begin
                        d.state    = ENG_IDLE;
                        d.done     = 1'b1;
                        d.done_buf = q.cur;
                    end else begin
                        d.cnt = q.cnt + LEN_W'(1);
                    end
                end
            end
            ENG_PROG0: begin
                d.sta[47:16] = {mem_data_i[7:0], mem_data_i[15:8],
                                mem_data_i[23:16], mem_data_i[31:24]};
                d.state = ENG_PROG1;
            end
            ENG_PROG1: begin
                d.sta[15:0] = {mem_data_i[7:0], mem_data_i[15:8]};
                d.state     = ENG_IDLE;
                d.done      = 1'b1;
                d.done_buf  = q.cur;
            end
            default: d.state = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ENG_IDLE;
            q.sta   <= STA_DEFAULT;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (q.cnt[1:0])
            2'd0:    tx_data_o = mem_data_i[7:0];
            2'd1:    tx_data_o = mem_data_i[15:8];
            2'd2:    tx_data_o = mem_data_i[23:16];
            default: tx_data_o = mem_data_i[31:24];
        endcase
    end

    assign tx_valid_o = (q.state == ENG_SEND);
    assign tx_last_o  = tx_valid_o && final_byte;
    assign sta_o      = q.sta;
    assign done_o     = q.done;
    assign done_buf_o = q.done_buf;

    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)));

    p_sta_only_prog_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sta != $past(q.sta)) |-> $past(q.state == ENG_PROG0 || q.state == ENG_PROG1));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

endmodule

// File: rtl/lite_tx_ctrl.sv
module lite_tx_ctrl #(
    parameter int          BUF_BYTES   = 2048,
    parameter logic [47:0] STA_DEFAULT = 48'h0200_0000_0001,
    localparam int HAW = $clog2(BUF_BYTES) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           host_en,
    input  logic           host_we,
    input  logic [HAW-1:0] host_addr,
    input  logic [31:0]    host_wdata,
    output logic [31:0]    host_rdata,
    output logic [7:0]     tx_data,
    output logic           tx_valid,
    input  logic           tx_ready,
    output logic           tx_last,
    output logic [47:0]    station_addr,
    output logic           irq
);
    localparam int MEM_AW = $clog2(BUF_BYTES) - 1;

    logic              mem_wr_en;
    logic [MEM_AW-1:0] mem_haddr;
    logic [31:0]       mem_wr_data;
    logic [31:0]       mem_hrd_data;
    logic [MEM_AW-1:0] mem_eaddr;
    logic [31:0]       mem_erd_data;
    logic [1:0]        pend;
    logic [1:0]        prog;
    logic [1:0][31:0]  len;
    logic              done;
    logic              done_buf;

    lite_tx_bufmem #(.AW(MEM_AW)) mem_i (
        .clk      (clk),
        .wr_en    (mem_wr_en),
        .wr_addr  (mem_haddr),
        .wr_data  (mem_wr_data),
        .hrd_addr (mem_haddr),
        .hrd_data (mem_hrd_data),
        .erd_addr (mem_eaddr),
        .erd_data (mem_erd_data)
    );

    lite_tx_regs #(.BUF_BYTES(BUF_BYTES)) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_en     (host_en),
        .host_we     (host_we),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .mem_wr_en   (mem_wr_en),
        .mem_addr    (mem_haddr),
        .mem_wr_data (mem_wr_data),
        .mem_rd_data (mem_hrd_data),
        .pend_o      (pend),
        .prog_o      (prog),
        .len_o       (len),
        .done_i      (done),
        .done_buf_i  (done_buf),
        .irq_o       (irq)
    );

    lite_tx_engine #(.BUF_BYTES(BUF_BYTES), .STA_DEFAULT(STA_DEFAULT)) eng_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_i     (pend),
        .prog_i     (prog),
        .len_i      (len),
        .mem_addr_o (mem_eaddr),
        .mem_data_i (mem_erd_data),
        .tx_data_o  (tx_data),
        .tx_valid_o (tx_valid),
        .tx_ready_i (tx_ready),
        .tx_last_o  (tx_last),
        .sta_o      (station_addr),
        .done_o     (done),
        .done_buf_o (done_buf)
    );

    p_last_has_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    p_irq_needs_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(done));

endmodule

// File: tb/lite_tx_ctrl_tb_top.sv
module lite_tx_ctrl_tb_top;

    localparam int          BUF_BYTES = 2048;
    localparam logic [47:0] STA_DEF   = 48'h0200_0000_0001;
    localparam int          HAW       = $clog2(BUF_BYTES) + 1;
    localparam int          LEN_OFF   = BUF_BYTES - 12;
    localparam int          GIE_OFF   = BUF_BYTES - 8;
    localparam int          CTRL_OFF  = BUF_BYTES - 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           host_en = 1'b0;
    logic           host_we = 1'b0;
    logic [HAW-1:0] host_addr = '0;
    logic [31:0]    host_wdata = '0;
    logic [31:0]    host_rdata;
    logic [7:0]     tx_data;
    logic           tx_valid;
    logic           tx_ready = 1'b1;
    logic           tx_last;
    logic [47:0]    station_addr;
    logic           irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    lite_tx_ctrl #(.BUF_BYTES(BUF_BYTES), .STA_DEFAULT(STA_DEF)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_en      (host_en),
        .host_we      (host_we),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .tx_data      (tx_data),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .tx_last      (tx_last),
        .station_addr (station_addr),
        .irq          (irq)
    );

    // ready pattern: 0 always, 1 never, 2 periodic stalls
    int          rdy_mode = 0;
    int unsigned cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        case (rdy_mode)
            0:       tx_ready = 1'b1;
            1:       tx_ready = 1'b0;
            default: tx_ready = (cyc % 3) != 0;
        endcase
    end

    // capture monitor, sampled mid-cycle
    logic [7:0] cap_d [4096];
    logic       cap_l [4096];
    int         cap_n = 0;
    int         irq_n = 0;
    int         stall_seen = 0;
    int         stall_bad = 0;
    logic       prev_stall = 1'b0;
    logic [7:0] prev_data = '0;
    logic       prev_last = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall && (!tx_valid || tx_data != prev_data || tx_last != prev_last))
                stall_bad++;
            if (tx_valid && tx_ready && cap_n < 4096) begin
                cap_d[cap_n] = tx_data;
                cap_l[cap_n] = tx_last;
                cap_n++;
            end
            if (tx_valid && !tx_ready) stall_seen++;
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
            prev_last  = tx_last;
            if (irq) irq_n++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int addr, input logic [31:0] data);
        @(negedge clk);
        host_en    = 1'b1;
        host_we    = 1'b1;
        host_addr  = HAW'(addr);
        host_wdata = data;
        @(negedge clk);
        host_en = 1'b0;
        host_we = 1'b0;
    endtask

    task automatic bus_read(input int addr, output logic [31:0] data);
        @(negedge clk);
        host_en   = 1'b1;
        host_we   = 1'b0;
        host_addr = HAW'(addr);
        @(negedge clk);
        host_en = 1'b0;
        data    = host_rdata;
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'(i * 7 + seed);
    endfunction

    task automatic fill(input int b, input int len, input int seed);
        for (int k = 0; k < (len + 3) / 4; k++)
            bus_write(b * BUF_BYTES + 4 * k,
                      {pat(4*k+3, seed), pat(4*k+2, seed), pat(4*k+1, seed), pat(4*k, seed)});
    endtask

    task automatic wait_idle(input int b);
        logic [31:0] v;
        for (int t = 0; t < 3000; t++) begin
            bus_read(b * BUF_BYTES + CTRL_OFF, v);
            if (!v[0]) break;
        end
    endtask

    task automatic wait_bytes(input int n);
        for (int t = 0; t < 20000 && cap_n < n; t++) @(negedge clk);
    endtask

    task automatic check_frame(input int start, input int len, input int seed, input string req);
        int bad = 0;
        for (int i = 0; i < len; i++) begin
            if (cap_d[start+i] !== pat(i, seed)) bad++;
            if (cap_l[start+i] !== (i == len - 1)) bad++;
        end
        check(bad == 0, req, 64'(bad), 64'd0);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check(!tx_valid && !irq, "R8", {62'd0, tx_valid, irq}, 64'd0);
        check(station_addr == STA_DEF, "R8", 64'(station_addr), 64'(STA_DEF));
        bus_read(CTRL_OFF, v);
        check(v == 0, "R8", 64'(v), 64'd0);
        bus_read(BUF_BYTES + LEN_OFF, v);
        check(v == 0, "R8", 64'(v), 64'd0);
    endtask

    task automatic t_readback;
        logic [31:0] v;
        bus_write(BUF_BYTES + 4, 32'hA5A5_1234);
        bus_read(BUF_BYTES + 4, v);
        check(v == 32'hA5A5_1234, "R1", 64'(v), 64'hA5A5_1234);
        bus_write(LEN_OFF, 32'hDEAD_0000);
        bus_read(LEN_OFF, v);
        check(v == 32'hDEAD_0000, "R2", 64'(v), 64'hDEAD_0000);
        bus_write(GIE_OFF, 32'h7FFF_FFFF);
        bus_read(GIE_OFF, v);
        check(v == 32'h7FFF_FFFF, "R2", 64'(v), 64'h7FFF_FFFF);
        // R10: S=0 stores bits, P reads 0, nothing starts
        cap_n = 0;
        bus_write(BUF_BYTES + CTRL_OFF, 32'hABCD_00FA);
        bus_read(BUF_BYTES + CTRL_OFF, v);
        check(v == 32'hABCD_00F8, "R10", 64'(v), 64'hABCD_00F8);
        repeat (10) @(negedge clk);
        check(cap_n == 0, "R10", 64'(cap_n), 64'd0);
        bus_write(BUF_BYTES + CTRL_OFF, 32'h0);
        bus_write(GIE_OFF, 32'h0);
    endtask

    task automatic t_send(input int b, input int len, input int seed, input int mode, input string req);
        logic [31:0] v;
        fill(b, len, seed);
        bus_write(b * BUF_BYTES + LEN_OFF, 32'(len));
        cap_n = 0;
        rdy_mode = mode;
        bus_write(b * BUF_BYTES + CTRL_OFF, 32'h1);
        wait_bytes(len);
        wait_idle(b);
        repeat (4) @(negedge clk);
        check(cap_n == len, req, 64'(cap_n), 64'(len));
        check_frame(0, len, seed, req);
        bus_read(b * BUF_BYTES + CTRL_OFF, v);
        check(v == 0, "R6", 64'(v), 64'd0);
        rdy_mode = 0;
    endtask

    task automatic t_stall;
        stall_seen = 0;
        stall_bad = 0;
        t_send(0, 23, 91, 2, "R4");
        check(stall_seen > 0 && stall_bad == 0, "R4", 64'(stall_bad), 64'd0);
    endtask

    task automatic t_program;
        bus_write(0, 32'h4433_2211);
        bus_write(4, 32'h0000_6655);
        cap_n = 0;
        bus_write(CTRL_OFF, 32'h3);
        wait_idle(0);
        check(station_addr == 48'h1122_3344_5566, "R5", 64'(station_addr), 64'h1122_3344_5566);
        check(cap_n == 0, "R5", 64'(cap_n), 64'd0);
    endtask

    task automatic t_busy;
        logic [31:0] v;
        logic [47:0] sta0;
        sta0 = station_addr;
        fill(0, 9, 17);
        bus_write(LEN_OFF, 32'd9);
        cap_n = 0;
        rdy_mode = 1;
        bus_write(CTRL_OFF, 32'h1);
        repeat (3) @(negedge clk);
        bus_read(CTRL_OFF, v);
        check(v == 32'h1, "R6", 64'(v), 64'h1);
        bus_write(CTRL_OFF, 32'h0000_000B);
        bus_read(CTRL_OFF, v);
        check(v == 32'h1, "R6", 64'(v), 64'h1);
        rdy_mode = 0;
        wait_bytes(9);
        wait_idle(0);
        repeat (10) @(negedge clk);
        check(cap_n == 9, "R6", 64'(cap_n), 64'd9);
        check_frame(0, 9, 17, "R6");
        check(station_addr == sta0, "R6", 64'(station_addr), 64'(sta0));
    endtask

    task automatic t_irq;
        // I set, global off: no pulse
        fill(1, 4, 3);
        bus_write(BUF_BYTES + LEN_OFF, 32'd4);
        irq_n = 0;
        bus_write(BUF_BYTES + CTRL_OFF, 32'h9);
        wait_idle(1);
        repeat (4) @(negedge clk);
        check(irq_n == 0, "R7", 64'(irq_n), 64'd0);
        // global on, I clear: no pulse
        bus_write(GIE_OFF, 32'h8000_0000);
        irq_n = 0;
        bus_write(BUF_BYTES + CTRL_OFF, 32'h1);
        wait_idle(1);
        repeat (4) @(negedge clk);
        check(irq_n == 0, "R7", 64'(irq_n), 64'd0);
        // both: one pulse
        irq_n = 0;
        bus_write(BUF_BYTES + CTRL_OFF, 32'h9);
        wait_idle(1);
        repeat (4) @(negedge clk);
        check(irq_n == 1, "R7", 64'(irq_n), 64'd1);
        // program op also interrupts
        irq_n = 0;
        bus_write(BUF_BYTES + CTRL_OFF, 32'hB);
        wait_idle(1);
        repeat (4) @(negedge clk);
        check(irq_n == 1, "R7", 64'(irq_n), 64'd1);
        check(station_addr == {pat(0,3), pat(1,3), pat(2,3), pat(3,3), 16'h0000} ||
              station_addr[47:16] == {pat(0,3), pat(1,3), pat(2,3), pat(3,3)},
              "R5", 64'(station_addr[47:16]), 64'({pat(0,3), pat(1,3), pat(2,3), pat(3,3)}));
    endtask

    task automatic t_zero_len;
        logic [31:0] v;
        bus_write(LEN_OFF, 32'd0);
        cap_n = 0;
        irq_n = 0;
        bus_write(CTRL_OFF, 32'h9);
        repeat (6) @(negedge clk);
        bus_read(CTRL_OFF, v);
        check(v == 32'h8, "R10", 64'(v), 64'h8);
        check(cap_n == 0 && irq_n == 1, "R10", {32'(cap_n), 32'(irq_n)}, {32'd0, 32'd1});
        bus_write(GIE_OFF, 32'h0);
        bus_write(CTRL_OFF, 32'h0);
        bus_write(BUF_BYTES + CTRL_OFF, 32'h0);
    endtask

    task automatic t_queue;
        logic [31:0] v;
        fill(1, 6, 40);
        bus_write(BUF_BYTES + LEN_OFF, 32'd6);
        fill(0, 5, 77);
        bus_write(LEN_OFF, 32'd5);
        cap_n = 0;
        rdy_mode = 1;
        bus_write(BUF_BYTES + CTRL_OFF, 32'h1);
        bus_write(CTRL_OFF, 32'h1);
        bus_read(CTRL_OFF, v);
        check(v == 32'h1, "R9", 64'(v), 64'h1);
        rdy_mode = 0;
        wait_bytes(11);
        wait_idle(0);
        repeat (4) @(negedge clk);
        check(cap_n == 11, "R9", 64'(cap_n), 64'd11);
        check_frame(0, 6, 40, "R9");
        check_frame(6, 5, 77, "R9");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_readback;
        t_send(0, 13, 5, 0, "R3");
        t_send(1, 8, 200, 0, "R1");
        t_stall;
        t_program;
        t_busy;
        t_irq;
        t_zero_len;
        t_queue;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule